// File: doc/BRIEF.md
# DMA Flow-Controlled Channel

This block is one DMA channel that copies a single block of data items from a source to a destination over a simple bus master port. Each side is either memory or a peripheral. Memory addresses advance by one per item. A peripheral sits at a fixed address and paces the channel through request/acknowledge handshake lines. These lines carry single-item and burst requests, and each side has its own polarity and enable setting.

The block length is set by a selectable flow controller. When the channel is the flow controller, it counts down a programmed item count. When the source or destination peripheral is the flow controller, that peripheral marks its final request with a last line. Only some pairings of transfer type and flow controller are accepted. A start with any other pairing raises an error flag, and the channel stays idle. When the destination peripheral is the flow controller and a prefetch bit is set, one source item may be read before the destination asks for it.

Configuration is held on static inputs and sampled when `start` is pulsed. When the block finishes, the channel clears its own enable and pulses `block_done`.

Top module: `dma_flow_channel`

## Requirements
- R1: `cfg_xfer_kind` bit 1 set means the source is a peripheral, and bit 0 set means the destination is a peripheral. `cfg_flow_sel` selects the flow controller: 0 = channel, 1 = source peripheral, 2 = destination peripheral, 3 = reserved. The legal pairs are: kind 0 with flow 0; kind 1 with flow 0 or 2; kind 2 with flow 0 or 1; kind 3 with flow 0. A start with any other pair, or with flow 0 and a zero item count, sets `cfg_error` on the next cycle, leaves `chan_en` low and issues no bus request. A legal start clears `cfg_error`.
- R2: Under channel flow control, exactly `cfg_block_items` items are copied. Memory-side addresses begin at the programmed base and step by one per item. A peripheral side keeps its programmed address.
- R3: A transaction moves `cfg_burst_len` items (a value of 0 counts as 1) when every peripheral side taking part raises its burst request. Otherwise it moves one item. Under channel flow control, the size is capped at the number of items remaining. A memory-to-memory transfer always uses burst-sized transactions.
- R4: After the last write of each transaction, every peripheral side taking part sees its acknowledge active for exactly one cycle. A memory side never sees an acknowledge.
- R5: Under peripheral flow control, the block ends after the transaction whose request came with that peripheral's last line active. It does not end before that.
- R6: When a side's polarity bit is 1, its request, last and acknowledge lines are active low. When the bit is 0, they are active high.
- R7: While a side's handshake enable is 0, its requests are ignored and its acknowledge is held at the inactive level. The channel then issues no bus request that would need that side. Transfers resume once the side is enabled.
- R8: With destination flow control and `cfg_prefetch` = 1, the channel reads one source item before any destination request. With `cfg_prefetch` = 0, it reads nothing until the destination requests. Each item is read exactly once, including when a request is already present at the moment a prefetch could start.
- R9: On completion, `chan_en` falls and `block_done` pulses for one cycle, both in the same cycle.
- R10: A bus request keeps its address, direction and data until `bus_ready` is high. Read data is taken in the cycle `bus_ready` is high. Every item is read before it is written.
- R11: A `start` pulse while `chan_en` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a block |
| cfg_xfer_kind | input | 2 | Transfer type: bit 1 source is a peripheral, bit 0 destination is a peripheral |
| cfg_flow_sel | input | 2 | Flow controller select |
| cfg_block_items | input | BLK_W | Item count used under channel flow control |
| cfg_burst_len | input | BURST_W | Items per burst transaction |
| cfg_src_addr | input | ADDR_W | Source base or peripheral address |
| cfg_dst_addr | input | ADDR_W | Destination base or peripheral address |
| cfg_src_hs_en | input | 1 | Source handshake enable |
| cfg_dst_hs_en | input | 1 | Destination handshake enable |
| cfg_src_pol | input | 1 | Source handshake active-low select |
| cfg_dst_pol | input | 1 | Destination handshake active-low select |
| cfg_prefetch | input | 1 | Allow source read-ahead under destination flow control |
| src_req_single | input | 1 | Source single-item request |
| src_req_burst | input | 1 | Source burst request |
| src_req_last | input | 1 | Source marks its final transaction |
| src_ack | output | 1 | Source transaction acknowledge |
| dst_req_single | input | 1 | Destination single-item request |
| dst_req_burst | input | 1 | Destination burst request |
| dst_req_last | input | 1 | Destination marks its final transaction |
| dst_ack | output | 1 | Destination transaction acknowledge |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid when bus_ready is high |
| bus_ready | input | 1 | Bus accepts or completes the request |
| chan_en | output | 1 | Channel enabled (busy) |
| cfg_error | output | 1 | Illegal configuration seen at the last start |
| block_done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same arbitration cycle: a source read-ahead becoming possible, and a destination request being present. The bench provokes this by raising the destination's single request, with its last line, before pulsing `start`. Both conditions are then true in the first cycle after start. The outcome is judged by counting bus reads and writes for the block, which must be exactly one of each, and by the captured word, which must equal the first source item. A second overlap is also watched at completion: the enable must be found low in the very cycle `block_done` is seen high.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_RD,
        ST_WR,
        ST_ACK
    } dfc_state_e;

    localparam logic [1:0] FC_CHAN = 2'd0;
    localparam logic [1:0] FC_SRC  = 2'd1;
    localparam logic [1:0] FC_DST  = 2'd2;

endpackage

// File: rtl/dfc_legal_check.sv
module dfc_legal_check
    import dfc_pkg::*;
(
    input  logic [1:0] xfer_kind,
    input  logic [1:0] flow_sel,
    input  logic       count_zero,
    output logic       legal
);
    logic pair_ok;

    always_comb begin
        unique case (xfer_kind)
            2'b00:   pair_ok = (flow_sel == FC_CHAN);
            2'b01:   pair_ok = (flow_sel == FC_CHAN) || (flow_sel == FC_DST);
            2'b10:   pair_ok = (flow_sel == FC_CHAN) || (flow_sel == FC_SRC);
            default: pair_ok = (flow_sel == FC_CHAN);
        endcase
    end

    // a channel-counted block must hold at least one item
    assign legal = pair_ok && !((flow_sel == FC_CHAN) && count_zero);

endmodule

// File: rtl/dfc_hs_side.sv
module dfc_hs_side (
    input  logic hs_en,
    input  logic hs_pol,
    input  logic pin_single,
    input  logic pin_burst,
    input  logic pin_last,
    input  logic ack_int,
    output logic act_single,
    output logic act_burst,
    output logic act_last,
    output logic ack_pin
);
    // polarity 1 = active low; a disabled side presents no request
    assign act_single = hs_en & (pin_single ^ hs_pol);
    assign act_burst  = hs_en & (pin_burst ^ hs_pol);
    assign act_last   = hs_en & (pin_last ^ hs_pol);
    assign ack_pin    = (hs_en & ack_int) ^ hs_pol;

endmodule

// File: rtl/dma_flow_channel.sv
module dma_flow_channel
    import dfc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int BLK_W   = 12,
    parameter int BURST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         cfg_xfer_kind,
    input  logic [1:0]         cfg_flow_sel,
    input  logic [BLK_W-1:0]   cfg_block_items,
    input  logic [BURST_W-1:0] cfg_burst_len,
    input  logic [ADDR_W-1:0]  cfg_src_addr,
    input  logic [ADDR_W-1:0]  cfg_dst_addr,
    input  logic               cfg_src_hs_en,
    input  logic               cfg_dst_hs_en,
    input  logic               cfg_src_pol,
    input  logic               cfg_dst_pol,
    input  logic               cfg_prefetch,
    input  logic               src_req_single,
    input  logic               src_req_burst,
    input  logic               src_req_last,
    output logic               src_ack,
    input  logic               dst_req_single,
    input  logic               dst_req_burst,
    input  logic               dst_req_last,
    output logic               dst_ack,
    output logic               bus_valid,
    output logic               bus_write,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_ready,
    output logic               chan_en,
    output logic               cfg_error,
    output logic               block_done
);
    localparam int CMP_W = (BLK_W > BURST_W) ? BLK_W : BURST_W;
    localparam int N_SIDE = 2;  // index 0 = source, 1 = destination

    typedef struct packed {
        dfc_state_e         st;
        logic [BURST_W-1:0] txn_left;
        logic [BLK_W-1:0]   blk_left;
        logic [ADDR_W-1:0]  src_a;
        logic [ADDR_W-1:0]  dst_a;
        logic [DATA_W-1:0]  hold;
        logic               hold_vld;
        logic               last_seen;
        logic               en;
        logic               err;
        logic               done;
    } dfc_regs_t;

    dfc_regs_t r_d, r_q;

    // handshake sides
    logic [N_SIDE-1:0] pin_s, pin_b, pin_l, side_en, side_pol;
    logic [N_SIDE-1:0] act_s, act_b, act_l, ack_i, ack_o;

    assign pin_s    = {dst_req_single, src_req_single};
    assign pin_b    = {dst_req_burst,  src_req_burst};
    assign pin_l    = {dst_req_last,   src_req_last};
    assign side_en  = {cfg_dst_hs_en,  cfg_src_hs_en};
    assign side_pol = {cfg_dst_pol,    cfg_src_pol};

    for (genvar g = 0; g < N_SIDE; g++) begin : g_side
        dfc_hs_side u_side (
            .hs_en      (side_en[g]),
            .hs_pol     (side_pol[g]),
            .pin_single (pin_s[g]),
            .pin_burst  (pin_b[g]),
            .pin_last   (pin_l[g]),
            .ack_int    (ack_i[g]),
            .act_single (act_s[g]),
            .act_burst  (act_b[g]),
            .act_last   (act_l[g]),
            .ack_pin    (ack_o[g])
        );
    end

    assign src_ack = ack_o[0];
    assign dst_ack = ack_o[1];

    logic legal;
    dfc_legal_check u_legal (
        .xfer_kind  (cfg_xfer_kind),
        .flow_sel   (cfg_flow_sel),
        .count_zero (cfg_block_items == '0),
        .legal      (legal)
    );

    // transaction decode
    logic [N_SIDE-1:0]  is_per, side_ok;
    logic               go, is_burst, fc_chan, last_now, pf_ok;
    logic [BURST_W-1:0] blen_eff, n_raw, n_sel;

    assign is_per   = {cfg_xfer_kind[0], cfg_xfer_kind[1]};
    assign side_ok  = ~is_per | act_s | act_b;
    assign go       = &side_ok;
    assign is_burst = &(~is_per | act_b);
    assign fc_chan  = (cfg_flow_sel == FC_CHAN);
    assign last_now = ((cfg_flow_sel == FC_SRC) && act_l[0]) ||
                      ((cfg_flow_sel == FC_DST) && act_l[1]);
    assign pf_ok    = (cfg_flow_sel == FC_DST) && cfg_prefetch &&
                      !is_per[0] && !r_q.hold_vld;
    assign blen_eff = (cfg_burst_len == '0) ? BURST_W'(1) : cfg_burst_len;
    assign n_raw    = is_burst ? blen_eff : BURST_W'(1);
    assign n_sel    = (fc_chan && (CMP_W'(r_q.blk_left) < CMP_W'(n_raw)))
                      ? BURST_W'(r_q.blk_left) : n_raw;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (!legal) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.err       = 1'b0;
                        r_d.en        = 1'b1;
                        r_d.src_a     = cfg_src_addr;
                        r_d.dst_a     = cfg_dst_addr;
                        r_d.blk_left  = cfg_block_items;
                        r_d.txn_left  = '0;
                        r_d.hold_vld  = 1'b0;
                        r_d.last_seen = 1'b0;
                        r_d.st        = ST_ARB;
                    end
                end
            end
            ST_ARB: begin
                if (go) begin
                    // a pending request wins over a read-ahead
                    r_d.txn_left  = n_sel;
                    r_d.last_seen = last_now;
                    r_d.st        = r_q.hold_vld ? ST_WR : ST_RD;
                end else if (pf_ok) begin
                    r_d.st = ST_RD;
                end
            end
            ST_RD: begin
                if (bus_ready) begin
                    r_d.hold     = bus_rdata;
                    r_d.hold_vld = 1'b1;
                    r_d.src_a    = r_q.src_a + {{(ADDR_W-1){1'b0}}, ~is_per[0]};
                    r_d.st       = (r_q.txn_left != '0) ? ST_WR : ST_ARB;
                end
            end
            ST_WR: begin
                if (bus_ready) begin
                    r_d.hold_vld = 1'b0;
                    r_d.dst_a    = r_q.dst_a + {{(ADDR_W-1){1'b0}}, ~is_per[1]};
                    r_d.txn_left = r_q.txn_left - BURST_W'(1);
                    if (fc_chan) begin
                        r_d.blk_left = r_q.blk_left - BLK_W'(1);
                    end
                    r_d.st = (r_q.txn_left == BURST_W'(1)) ? ST_ACK : ST_RD;
                end
            end
            ST_ACK: begin
                if (fc_chan ? (r_q.blk_left == '0) : r_q.last_seen) begin
                    r_d.st   = ST_IDLE;
                    r_d.en   = 1'b0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = ST_ARB;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_i      = (r_q.st == ST_ACK) ? is_per : '0;
    assign bus_valid  = (r_q.st == ST_RD) || (r_q.st == ST_WR);
    assign bus_write  = (r_q.st == ST_WR);
    assign bus_addr   = (r_q.st == ST_WR) ? r_q.dst_a : r_q.src_a;
    assign bus_wdata  = r_q.hold;
    assign chan_en    = r_q.en;
    assign cfg_error  = r_q.err;
    assign block_done = r_q.done;

endmodule

// File: rtl/dfc_channel_chk.sv
module dfc_channel_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chan_en,
    input logic              cfg_error,
    input logic              block_done,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              src_ack,
    input logic              dst_ack,
    input logic              cfg_src_pol,
    input logic              cfg_dst_pol
);
    a_r9_done_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> (!chan_en && $past(chan_en)));

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !block_done);

    a_r1_error_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> !chan_en);

    a_r10_bus_only_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> chan_en);

    a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));

    a_r4_src_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack ^ cfg_src_pol) |=> !(src_ack ^ cfg_src_pol));

    a_r4_dst_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_ack ^ cfg_dst_pol) |=> !(dst_ack ^ cfg_dst_pol));

endmodule

bind dma_flow_channel dfc_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (chan_en),
    .cfg_error   (cfg_error),
    .block_done  (block_done),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_ready   (bus_ready),
    .bus_addr    (bus_addr),
    .src_ack     (src_ack),
    .dst_ack     (dst_ack),
    .cfg_src_pol (cfg_src_pol),
    .cfg_dst_pol (cfg_dst_pol)
);

// File: tb/dma_flow_channel_bench.sv
module dma_flow_channel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int BLK_W = 12;
    localparam int BURST_W = 4;
    localparam logic [7:0] SP = 8'hF0;
    localparam logic [7:0] DP = 8'hF8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] kind = '0, flow = '0;
    logic [BLK_W-1:0] blk = '0;
    logic [BURST_W-1:0] blen = '0;
    logic [ADDR_W-1:0] sa = '0, da = '0;
    logic s_en = 1'b1, d_en = 1'b1, s_pol = 1'b0, d_pol = 1'b0, pf = 1'b0;
    logic s_sg = 1'b0, s_bu = 1'b0, s_la = 1'b0, d_sg = 1'b0, d_bu = 1'b0, d_la = 1'b0;
    logic src_ack, dst_ack, bus_valid, bus_write, bus_ready, chan_en, cfg_error, block_done;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata;

    logic stall_en = 1'b0;
    logic tick = 1'b0;
    logic [31:0] mem [0:255];
    logic [31:0] cap [0:63];
    logic [31:0] pval = 32'd100;
    int cap_n = 0, rd_cnt = 0, wr_cnt = 0, s_ack_cnt = 0, d_ack_cnt = 0, done_cnt = 0;
    int n_chk = 0, n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_flow_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .BURST_W(BURST_W))
    u_dma_flow_channel (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_xfer_kind(kind), .cfg_flow_sel(flow), .cfg_block_items(blk), .cfg_burst_len(blen),
        .cfg_src_addr(sa), .cfg_dst_addr(da), .cfg_src_hs_en(s_en), .cfg_dst_hs_en(d_en),
        .cfg_src_pol(s_pol), .cfg_dst_pol(d_pol), .cfg_prefetch(pf),
        .src_req_single(s_sg), .src_req_burst(s_bu), .src_req_last(s_la), .src_ack(src_ack),
        .dst_req_single(d_sg), .dst_req_burst(d_bu), .dst_req_last(d_la), .dst_ack(dst_ack),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .chan_en(chan_en), .cfg_error(cfg_error), .block_done(block_done)
    );

    // memory and peripheral data model
    always @(posedge clk) tick <= ~tick;
    assign bus_ready = !stall_en || tick;
    assign bus_rdata = (bus_addr[7:0] == SP) ? pval : mem[bus_addr[7:0]];

    always @(posedge clk) begin
        if (bus_valid && bus_ready) begin
            if (bus_write) begin
                wr_cnt++;
                if (bus_addr[7:0] == DP) begin
                    cap[cap_n[5:0]] <= bus_wdata;
                    cap_n <= cap_n + 1;
                end else begin
                    mem[bus_addr[7:0]] <= bus_wdata;
                end
            end else begin
                rd_cnt++;
                if (bus_addr[7:0] == SP) pval <= pval + 32'd1;
            end
        end
        if (src_ack ^ s_pol) s_ack_cnt++;
        if (dst_ack ^ d_pol) d_ack_cnt++;
        if (block_done) done_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        bit seen = 1'b0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (block_done) begin seen = 1'b1; break; end
        end
        check(seen, "R9 block_done pulse", int'(seen), 1);
        check(!chan_en, "R9 enable low with done", int'(chan_en), 0);
        @(negedge clk);
        check(!block_done, "R9 done lasts one cycle", int'(block_done), 0);
    endtask

    task automatic src_set(input bit s, input bit b, input bit l);
        s_sg = s ^ s_pol; s_bu = b ^ s_pol; s_la = l ^ s_pol;
    endtask

    task automatic dst_set(input bit s, input bit b, input bit l);
        d_sg = s ^ d_pol; d_bu = b ^ d_pol; d_la = l ^ d_pol;
    endtask

    task automatic src_wait_ack();
        bit seen = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (src_ack ^ s_pol) begin seen = 1'b1; break; end
        end
        src_set(0, 0, 0);
        check(seen, "R4 source acknowledge", int'(seen), 1);
    endtask

    task automatic dst_wait_ack();
        bit seen = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (dst_ack ^ d_pol) begin seen = 1'b1; break; end
        end
        dst_set(0, 0, 0);
        check(seen, "R4 destination acknowledge", int'(seen), 1);
    endtask

    task automatic src_txn(input bit burst, input bit last);
        @(negedge clk); src_set(!burst, burst, last); src_wait_ack();
    endtask

    task automatic dst_txn(input bit burst, input bit last);
        @(negedge clk); dst_set(!burst, burst, last); dst_wait_ack();
    endtask

    function automatic bit legal_exp(input int k, input int f);
        case (k)
            0: return f == 0;
            1: return f == 0 || f == 2;
            2: return f == 0 || f == 1;
            default: return f == 0;
        endcase
    endfunction

    task automatic t_reset();
        check(!chan_en && !block_done && !bus_valid && !cfg_error, "R9 reset idle outputs",
              int'({chan_en, block_done, bus_valid, cfg_error}), 0);
        check(!src_ack && !dst_ack, "R6 acknowledges inactive at reset", int'({src_ack, dst_ack}), 0);
    endtask

    task automatic t_illegal();
        int rd0 = rd_cnt;
        blk = 12'd4; blen = 4'd2;
        for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 4; f++) begin
                if (!legal_exp(k, f)) begin
                    kind = 2'(k); flow = 2'(f);
                    pulse_start();
                    check(cfg_error && !chan_en, "R1 illegal pair rejected", int'({cfg_error, chan_en}), 2);
                end
            end
        end
        kind = 2'd0; flow = 2'd0; blk = '0;
        pulse_start();
        check(cfg_error && !chan_en, "R1 zero count rejected", int'({cfg_error, chan_en}), 2);
        repeat (5) @(negedge clk);
        check(rd_cnt == rd0, "R1 no bus traffic after error", rd_cnt - rd0, 0);
    endtask

    task automatic t_mem2mem();
        int rd0 = rd_cnt, wr0 = wr_cnt, bad = 0;
        kind = 2'd0; flow = 2'd0; blk = 12'd10; blen = 4'd4; sa = 16'h0000; da = 16'h0040;
        stall_en = 1'b1;
        pulse_start();
        check(!cfg_error && chan_en, "R1 legal start clears error", int'({cfg_error, chan_en}), 1);
        repeat (4) @(negedge clk);
        sa = 16'h0008;                 // a restart would copy from a shifted base
        pulse_start();                 // R11: ignored while busy
        sa = 16'h0000;
        wait_done();
        stall_en = 1'b0;
        check(wr_cnt - wr0 == 10, "R2 channel count writes", wr_cnt - wr0, 10);
        check(rd_cnt - rd0 == 10, "R11 busy start ignored (reads)", rd_cnt - rd0, 10);
        for (int i = 0; i < 10; i++) if (mem[8'h40 + i] !== 32'hA000 + i) bad++;
        check(bad == 0, "R10 data copied under bus stalls", bad, 0);
        check(s_ack_cnt == 0 && d_ack_cnt == 0, "R4 memory sides get no acknowledge",
              s_ack_cnt + d_ack_cnt, 0);
    endtask

    task automatic t_src_flow();
        int wr0 = wr_cnt, sk0 = s_ack_cnt, dk0 = d_ack_cnt, bad = 0;
        logic [31:0] pv0 = pval;
        kind = 2'd2; flow = 2'd1; blk = '0; blen = 4'd3; sa = {8'h00, SP}; da = 16'h0080;
        s_pol = 1'b1; src_set(0, 0, 0);
        @(negedge clk);
        check(src_ack == 1'b1, "R6 active-low acknowledge idles high", int'(src_ack), 1);
        pulse_start();
        src_txn(1, 0);
        src_txn(1, 0);
        check(chan_en, "R5 no end before last", int'(chan_en), 1);
        src_txn(0, 1);
        wait_done();
        check(wr_cnt - wr0 == 7, "R3 burst 3 + burst 3 + single", wr_cnt - wr0, 7);
        for (int i = 0; i < 7; i++) if (mem[8'h80 + i] !== pv0 + 32'(i)) bad++;
        check(bad == 0, "R2 fixed peripheral address, stepping memory", bad, 0);
        check(s_ack_cnt - sk0 == 3, "R4 one source ack per transaction", s_ack_cnt - sk0, 3);
        check(d_ack_cnt == dk0, "R4 memory destination unacknowledged", d_ack_cnt - dk0, 0);
        s_pol = 1'b0; src_set(0, 0, 0);
    endtask

    task automatic t_dst_pf(input bit pf_on, input logic [7:0] base);
        int rd0 = rd_cnt, wr0 = wr_cnt, c0 = cap_n, bad = 0;
        kind = 2'd1; flow = 2'd2; blen = 4'd2; sa = {8'h00, base}; da = {8'h00, DP}; pf = pf_on;
        pulse_start();
        repeat (10) @(negedge clk);
        check(rd_cnt - rd0 == int'(pf_on), "R8 read-ahead before request", rd_cnt - rd0, int'(pf_on));
        check(wr_cnt == wr0, "R8 no write before request", wr_cnt - wr0, 0);
        dst_txn(0, 0);
        check(chan_en, "R5 destination flow continues", int'(chan_en), 1);
        dst_txn(1, 1);
        wait_done();
        check(rd_cnt - rd0 == 3 && wr_cnt - wr0 == 3, "R8 each item read once",
              rd_cnt - rd0, 3);
        for (int i = 0; i < 3; i++) if (cap[(c0 + i) % 64] !== 32'hA000 + 32'(base) + 32'(i)) bad++;
        check(bad == 0, "R10 destination data order", bad, 0);
        pf = 1'b0;
    endtask

    task automatic t_collision();
        int rd0 = rd_cnt, wr0 = wr_cnt, c0 = cap_n;
        kind = 2'd1; flow = 2'd2; blen = 4'd2; sa = 16'h0030; da = {8'h00, DP}; pf = 1'b1;
        @(negedge clk); dst_set(1, 0, 1);
        pulse_start();
        dst_wait_ack();
        wait_done();
        check(rd_cnt - rd0 == 1 && wr_cnt - wr0 == 1, "R8 request meets read-ahead",
              (rd_cnt - rd0) * 10 + (wr_cnt - wr0), 11);
        check(cap[c0 % 64] === 32'hA030, "R8 collision data", int'(cap[c0 % 64]), 32'hA030);
        pf = 1'b0;
    endtask

    task automatic t_hs_off();
        int rd0 = rd_cnt, wr0 = wr_cnt, sk0 = s_ack_cnt;
        kind = 2'd2; flow = 2'd0; blk = 12'd2; blen = 4'd2; sa = {8'h00, SP}; da = 16'h00C0;
        s_en = 1'b0;
        @(negedge clk); src_set(0, 1, 0);
        pulse_start();
        repeat (20) @(negedge clk);
        check(rd_cnt == rd0 && chan_en, "R7 disabled request ignored", rd_cnt - rd0, 0);
        check(s_ack_cnt == sk0 && src_ack == 1'b0, "R7 acknowledge held inactive",
              s_ack_cnt - sk0, 0);
        s_en = 1'b1;
        src_wait_ack();
        wait_done();
        check(wr_cnt - wr0 == 2, "R7 resumes once enabled", wr_cnt - wr0, 2);
    endtask

    task automatic t_per2per();
        int c0 = cap_n, sk0 = s_ack_cnt, dk0 = d_ack_cnt, bad = 0;
        logic [31:0] pv0 = pval;
        kind = 2'd3; flow = 2'd0; blk = 12'd5; blen = 4'd2; sa = {8'h00, SP}; da = {8'h00, DP};
        pulse_start();
        for (int t = 0; t < 3; t++) begin
            fork
                src_txn(1, 0);
                dst_txn(1, 0);
            join
        end
        wait_done();
        check(cap_n - c0 == 5, "R3 burst capped by remaining count", cap_n - c0, 5);
        for (int i = 0; i < 5; i++) if (cap[(c0 + i) % 64] !== pv0 + 32'(i)) bad++;
        check(bad == 0, "R2 peripheral to peripheral data", bad, 0);
        check(s_ack_cnt - sk0 == 3 && d_ack_cnt - dk0 == 3, "R4 both sides acknowledged per transaction",
              s_ack_cnt - sk0, 3);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA000 + 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_illegal();
        t_mem2mem();
        t_src_flow();
        t_dst_pf(1'b0, 8'h10);
        t_dst_pf(1'b1, 8'h20);
        t_collision();
        t_hs_off();
        t_per2per();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule